// File: doc/BRIEF.md
# ADC conversion timing sequencer

This block is the digital control sequencer of a successive-approximation converter. It picks one of four clock sources, runs it through a divide-by-1/2/4/8 prescaler to get the conversion clock, and steps each conversion through two phases. The first is a sampling phase whose length is programmable. The second is a conversion phase of fixed length. When the conversion phase ends, the block captures the result word from the analog stub and sets a completion flag. It raises an interrupt if interrupts are enabled.

A conversion starts in one of two ways. Software starts it by writing the channel register, or an external pin starts it when the hardware trigger is selected. In continuous mode a new conversion begins as soon as the previous one finishes. Channel code 5'h1F parks the block in a powered-down state in which nothing runs. Software reaches all settings through a small write/read register port.

The sequencer has four states:
- **OFF**: entered at reset, or on a write of channel 1F.
- **IDLE**: armed and waiting for a hardware trigger.
- **SAMPLE**: the sampling phase.
- **CONV**: the conversion phase.

Its transitions are:
- *restart*: any channel write. It goes to OFF, IDLE or SAMPLE depending on the new code and the trigger select.
- *hw_start*: IDLE to SAMPLE.
- *sample_done*: SAMPLE to CONV.
- *conv_done_single*: CONV to IDLE.
- *conv_done_cont*: CONV to SAMPLE.

Top module: `sarseq_top`

## Requirements
- R1: After reset the channel reads 5'h1F (block off), interrupt enable, completion flag and result read 0, and `busy_o` and `irq_o` are low.
- R2: Timing register bits [1:0] select the conversion clock source: 0 = every bus clock, 1 = `alt2_tick`, 2 = `alt_tick`, 3 = `async_tick`. Only strobes of the selected source advance the prescaler.
- R3: Timing register bits [3:2] = d set the prescaler. One conversion clock is produced for every 2^d selected source strobes, counted from the start of a conversion.
- R4: With timing bit [4] = 0 the sampling phase lasts 4 conversion clocks. With bit [4] = 1, bits [6:5] = 0, 1, 2, 3 give 24, 16, 10 and 6 conversion clocks.
- R5: The conversion phase lasts CONV_CYCLES conversion clocks (default 14). It lasts 2 more when timing bit [7] (high-speed) is set.
- R6: A write to the control register (address 0) with mode bit [0] = 0 and a channel other than 1F starts a conversion. `busy_o` is high from the next cycle until the last conversion clock of the conversion phase has been consumed.
- R7: At the end of a conversion the result register (address 3) captures `ana_result` and the completion flag (control bit [6]) sets. `irq_o` is high exactly while the flag and the enable (control bit [5]) are both 1.
- R8: Reading address 3 clears the completion flag. A control write clears the flag, aborts any conversion in progress and restarts the timing from the beginning.
- R9: While the channel is 1F no conversion runs, whether software or the hardware trigger requests one.
- R10: With mode bit [0] = 1 a control write only arms the block. A cycle with `hw_trig` high while armed starts a conversion.
- R11: With mode bit [1] = 1 each conversion is followed at once by the next, and `busy_o` stays high. Clearing the bit lets the current conversion finish, and then the block waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears the flag on address 3) |
| addr | input | 2 | Register address: 0 control, 1 timing, 2 mode, 3 result |
| wdata | input | 8 | Write data |
| rdata | output | RES_W | Read data for `addr` |
| hw_trig | input | 1 | Hardware start trigger |
| alt2_tick | input | 1 | Secondary alternate clock strobe |
| alt_tick | input | 1 | Alternate clock strobe |
| async_tick | input | 1 | Asynchronous clock strobe |
| ana_result | input | RES_W | Result word from the analog stub |
| busy_o | output | 1 | Conversion active |
| irq_o | output | 1 | Completion interrupt |

## Verification
The bench measures each conversion in strobes of the selected source. A design that miscounted a sample code, dropped the two high-speed cycles, or let a divider free-run across starts would show up as a wrong count. An off-by-one in the phase counters would also change the count. A second control write part-way through a conversion checks that the timing restarts in full and the stale flag drops at once; a design that only cleared the flag would end early. Channel 1F is hit with a hardware pulse, and an armed block is given a software write. A design that woke from either would raise `busy_o`. Continuous mode is checked for an unbroken `busy_o` across the boundary and a second captured result. A design that passed through IDLE between conversions would drop busy for a cycle.

// File: rtl/sarseq_pkg.sv
package sarseq_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_IDLE   = 2'd1,
        ST_SAMPLE = 2'd2,
        ST_CONV   = 2'd3
    } seq_state_t;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_TIME = 2'd1;
    localparam logic [1:0] A_MODE = 2'd2;
    localparam logic [1:0] A_DATA = 2'd3;

    localparam logic [4:0] CHAN_OFF    = 5'h1F;
    localparam int         BASE_SAMPLE = 4;
    localparam int         LONG_MAX    = 24;
    localparam int         HS_EXTRA    = 2;

    // timing register layout, MSB first
    typedef struct packed {
        logic       hs;
        logic [1:0] long_sel;
        logic       long_en;
        logic [1:0] div_sel;
        logic [1:0] src_sel;
    } timing_cfg_t;

    function automatic int sample_total(input logic long_en, input logic [1:0] sel);
        if (!long_en) return BASE_SAMPLE;
        case (sel)
            2'd0:    return LONG_MAX;
            2'd1:    return 16;
            2'd2:    return 10;
            default: return 6;
        endcase
    endfunction

endpackage

// File: rtl/sarseq_regs.sv
module sarseq_regs
    import sarseq_pkg::*;
#(
    parameter int RES_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [1:0]       addr,
    input  logic [7:0]       wdata,
    input  logic             conv_end,
    input  logic [RES_W-1:0] ana_result,
    output logic [4:0]       chan,
    output logic             ie,
    output timing_cfg_t      tcfg,
    output logic             trig_hw,
    output logic             cont,
    output logic             done,
    output logic [RES_W-1:0] result,
    output logic             restart,
    output logic             restart_off,
    output logic [RES_W-1:0] rdata
);

    always_comb begin
        restart     = wr_en && (addr == A_CTRL);
        restart_off = (wdata[4:0] == CHAN_OFF);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan    <= CHAN_OFF;
            ie      <= 1'b0;
            tcfg    <= '0;
            trig_hw <= 1'b0;
            cont    <= 1'b0;
        end else if (wr_en) begin
            case (addr)
                A_CTRL: begin
                    chan <= wdata[4:0];
                    ie   <= wdata[5];
                end
                A_TIME: tcfg <= timing_cfg_t'(wdata);
                A_MODE: begin
                    trig_hw <= wdata[0];
                    cont    <= wdata[1];
                end
                default: ;
            endcase
        end
    end

    // flag: abort beats completion, completion beats read-clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done   <= 1'b0;
            result <= '0;
        end else begin
            if (restart)
                done <= 1'b0;
            else if (conv_end)
                done <= 1'b1;
            else if (rd_en && (addr == A_DATA))
                done <= 1'b0;
            if (conv_end)
                result <= ana_result;
        end
    end

    always_comb begin
        case (addr)
            A_CTRL:  rdata = RES_W'({done, ie, chan});
            A_TIME:  rdata = RES_W'(tcfg);
            A_MODE:  rdata = RES_W'({cont, trig_hw});
            default: rdata = result;
        endcase
    end

endmodule

// File: rtl/sarseq_clkgen.sv
module sarseq_clkgen #(
    parameter int DIV_SEL_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           src_sel,
    input  logic [DIV_SEL_W-1:0] div_sel,
    input  logic                 run,
    input  logic                 restart,
    input  logic                 alt2_tick,
    input  logic                 alt_tick,
    input  logic                 async_tick,
    output logic                 ctick
);

    localparam int MAX_DIV = 1 << ((1 << DIV_SEL_W) - 1);
    localparam int PC_W    = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;

    logic [3:0]      src_vec;
    logic            src;
    logic [PC_W-1:0] pcnt;
    logic [PC_W-1:0] div_last;

    always_comb begin
        src_vec  = {async_tick, alt_tick, alt2_tick, 1'b1};
        src      = src_vec[src_sel];
        div_last = PC_W'((1 << div_sel) - 1);
        ctick    = run && src && (pcnt == div_last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pcnt <= '0;
        else if (!run || restart)
            pcnt <= '0;
        else if (src)
            pcnt <= ctick ? '0 : pcnt + 1'b1;
    end

endmodule

// File: rtl/sarseq_fsm.sv
module sarseq_fsm
    import sarseq_pkg::*;
#(
    parameter int CONV_CYCLES = 14
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        restart,
    input  logic        restart_off,
    input  logic        trig_hw,
    input  logic        cont,
    input  logic        hw_trig,
    input  logic        ctick,
    input  timing_cfg_t tcfg,
    output logic        busy,
    output logic        conv_end,
    output seq_state_t  state
);

    localparam int CLEN_MAX = CONV_CYCLES + HS_EXTRA;
    localparam int CNT_MAX  = (CLEN_MAX > LONG_MAX) ? CLEN_MAX : LONG_MAX;
    localparam int CNT_W    = $clog2(CNT_MAX + 1);

    seq_state_t nxt;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] slen_last;
    logic [CNT_W-1:0] clen_last;
    logic samp_last, conv_last, cnt_clr, cnt_inc;

    always_comb begin
        slen_last = CNT_W'(sample_total(tcfg.long_en, tcfg.long_sel) - 1);
        clen_last = CNT_W'(CONV_CYCLES - 1 + (tcfg.hs ? HS_EXTRA : 0));
        samp_last = (cnt == slen_last);
        conv_last = (cnt == clen_last);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_OFF;
        else
            state <= nxt;
    end

    // transitions
    always_comb begin
        nxt     = state;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        if (restart) begin
            nxt     = restart_off ? ST_OFF : (trig_hw ? ST_IDLE : ST_SAMPLE);
            cnt_clr = 1'b1;
        end else begin
            unique case (state)
                ST_OFF: ;
                ST_IDLE: begin
                    if (trig_hw && hw_trig) begin
                        nxt     = ST_SAMPLE;
                        cnt_clr = 1'b1;
                    end
                end
                ST_SAMPLE: begin
                    if (ctick) begin
                        if (samp_last) begin
                            nxt     = ST_CONV;
                            cnt_clr = 1'b1;
                        end else begin
                            cnt_inc = 1'b1;
                        end
                    end
                end
                ST_CONV: begin
                    if (ctick) begin
                        if (conv_last) begin
                            nxt     = cont ? ST_SAMPLE : ST_IDLE;
                            cnt_clr = 1'b1;
                        end else begin
                            cnt_inc = 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        busy     = (state == ST_SAMPLE) || (state == ST_CONV);
        conv_end = !restart && (state == ST_CONV) && ctick && conv_last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt_clr)
            cnt <= '0;
        else if (cnt_inc)
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/sarseq_top.sv
module sarseq_top
    import sarseq_pkg::*;
#(
    parameter int RES_W       = 16,
    parameter int CONV_CYCLES = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [1:0]       addr,
    input  logic [7:0]       wdata,
    output logic [RES_W-1:0] rdata,
    input  logic             hw_trig,
    input  logic             alt2_tick,
    input  logic             alt_tick,
    input  logic             async_tick,
    input  logic [RES_W-1:0] ana_result,
    output logic             busy_o,
    output logic             irq_o
);

    logic [4:0]       chan_w;
    logic             ie_w, trig_hw_w, cont_w, done_w;
    logic             restart_w, restart_off_w, ctick_w, conv_end_w;
    logic [RES_W-1:0] result_w;
    timing_cfg_t      tcfg_w;
    seq_state_t       state_w;

    sarseq_regs #(.RES_W(RES_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .addr        (addr),
        .wdata       (wdata),
        .conv_end    (conv_end_w),
        .ana_result  (ana_result),
        .chan        (chan_w),
        .ie          (ie_w),
        .tcfg        (tcfg_w),
        .trig_hw     (trig_hw_w),
        .cont        (cont_w),
        .done        (done_w),
        .result      (result_w),
        .restart     (restart_w),
        .restart_off (restart_off_w),
        .rdata       (rdata)
    );

    sarseq_clkgen #(.DIV_SEL_W(2)) u_clkgen (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_sel    (tcfg_w.src_sel),
        .div_sel    (tcfg_w.div_sel),
        .run        (busy_o),
        .restart    (restart_w),
        .alt2_tick  (alt2_tick),
        .alt_tick   (alt_tick),
        .async_tick (async_tick),
        .ctick      (ctick_w)
    );

    sarseq_fsm #(.CONV_CYCLES(CONV_CYCLES)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (restart_w),
        .restart_off (restart_off_w),
        .trig_hw     (trig_hw_w),
        .cont        (cont_w),
        .hw_trig     (hw_trig),
        .ctick       (ctick_w),
        .tcfg        (tcfg_w),
        .busy        (busy_o),
        .conv_end    (conv_end_w),
        .state       (state_w)
    );

    assign irq_o = done_w && ie_w;

endmodule

// File: rtl/sarseq_checker.sv
module sarseq_checker
    import sarseq_pkg::*;
#(
    parameter int RES_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic [1:0]       addr,
    input logic             hw_trig,
    input logic             busy_o,
    input logic             irq_o,
    input logic             done_w,
    input logic [4:0]       chan_w,
    input logic [RES_W-1:0] result_w
);

    assert_off_never_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_w == CHAN_OFF) |-> !busy_o);

    assert_start_has_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> ($past(wr_en && (addr == A_CTRL)) || $past(hw_trig)));

    assert_flag_after_conv_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_w) |-> $past(busy_o));

    assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> $stable(result_w));

    assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> done_w);

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr == A_DATA) && !busy_o) |=> !done_w);

endmodule

bind sarseq_top sarseq_checker #(.RES_W(RES_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .hw_trig  (hw_trig),
    .busy_o   (busy_o),
    .irq_o    (irq_o),
    .done_w   (done_w),
    .chan_w   (chan_w),
    .result_w (result_w)
);

// File: tb/sarseq_top_test.sv
module sarseq_top_test;

    localparam int CONV = 14;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, hw_trig = 1'b0;
    logic        a2 = 1'b0, a1 = 1'b0, as_t = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [7:0]  wdata = 8'd0;
    logic [15:0] ana = 16'd0;
    logic [15:0] rdata;
    logic        busy, irq;

    int total = 0, bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    sarseq_top #(.RES_W(16), .CONV_CYCLES(CONV)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .hw_trig(hw_trig), .alt2_tick(a2),
        .alt_tick(a1), .async_tick(as_t), .ana_result(ana), .busy_o(busy), .irq_o(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // clock source strobes
    initial begin
        int fc = 0;
        forever begin
            @(negedge clk);
            fc++;
            a2   = (fc % 2 == 0);
            a1   = (fc % 3 == 0);
            as_t = (fc % 5 == 1);
        end
    end

    function automatic bit sel(input int s);
        case (s)
            0: return 1'b1;
            1: return a2;
            2: return a1;
            default: return as_t;
        endcase
    endfunction

    // behavioural reference, advanced on each rising edge
    int m_ph, m_pc, m_cnt;
    bit m_done, m_ie, m_trig, m_cont;
    logic [7:0] m_cfg;

    always @(posedge clk) begin
        int divn, slen, clen, nph, npc, ncnt;
        bit src, run, tick, wr0, fin;
        if (!rst_n) begin
            m_ph = 0; m_pc = 0; m_cnt = 0; m_done = 0; m_ie = 0;
            m_trig = 0; m_cont = 0; m_cfg = 8'h00;
        end else begin
            src  = sel(int'(m_cfg[1:0]));
            run  = (m_ph >= 2);
            divn = 1 << m_cfg[3:2];
            tick = run && src && (m_pc == divn - 1);
            if (!m_cfg[4]) slen = 4;
            else case (m_cfg[6:5]) 0: slen = 24; 1: slen = 16; 2: slen = 10; default: slen = 6; endcase
            clen = CONV + (m_cfg[7] ? 2 : 0);
            wr0  = wr_en && (addr == 2'd0);
            fin  = !wr0 && m_ph == 3 && tick && (m_cnt == clen - 1);
            npc  = (!run || wr0) ? 0 : (src ? (tick ? 0 : m_pc + 1) : m_pc);
            nph  = m_ph; ncnt = m_cnt;
            if (wr0) begin
                nph = (wdata[4:0] == 5'h1F) ? 0 : (m_trig ? 1 : 2); ncnt = 0;
            end else if (m_ph == 1) begin
                if (m_trig && hw_trig) begin nph = 2; ncnt = 0; end
            end else if (m_ph == 2 && tick) begin
                if (m_cnt == slen - 1) begin nph = 3; ncnt = 0; end else ncnt = m_cnt + 1;
            end else if (m_ph == 3 && tick) begin
                if (fin) begin nph = m_cont ? 2 : 1; ncnt = 0; end else ncnt = m_cnt + 1;
            end
            if (wr0) m_done = 0;
            else if (fin) m_done = 1;
            else if (rd_en && addr == 2'd3) m_done = 0;
            if (wr_en) begin
                if (addr == 2'd0) m_ie = wdata[5];
                if (addr == 2'd1) m_cfg = wdata;
                if (addr == 2'd2) begin m_trig = wdata[0]; m_cont = wdata[1]; end
            end
            m_ph = nph; m_pc = npc; m_cnt = ncnt;
        end
    end

    // per-cycle comparison against the reference
    initial forever begin
        @(negedge clk);
        #2;
        if (rst_n && !finished) begin
            chk(busy == (m_ph >= 2), "R6 per-cycle busy", busy, m_ph >= 2);
            chk(irq == (m_done && m_ie), "R7 per-cycle irq", irq, m_done && m_ie);
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        @(negedge clk); rd_en = 1'b1; addr = a;
        #2 v = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic measure(input int s, output int n);
        n = 0;
        for (int i = 0; i < 20000; i++) begin
            #2;
            if (!busy) break;
            if (sel(s)) n++;
            @(negedge clk);
        end
    endtask

    task automatic pulse_hw();
        @(negedge clk); hw_trig = 1'b1;
        @(negedge clk); hw_trig = 1'b0;
    endtask

    task automatic conv_check(input logic [7:0] cfg, input int exp, input string req);
        int n;
        wr(2'd1, cfg);
        wr(2'd0, 8'h23);
        measure(int'(cfg[1:0]), n);
        chk(n == exp, req, n, exp);
    endtask

    initial begin
        logic [15:0] v;
        int n;
        bit seen;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk(busy == 0, "R1 busy after reset", busy, 0);
        chk(irq == 0, "R1 irq after reset", irq, 0);
        rd(2'd0, v); chk(v == 16'h001F, "R1 control after reset", v, 16'h001F);
        rd(2'd3, v); chk(v == 16'h0000, "R1 result after reset", v, 0);

        // basic software conversion (R4 short sample, R6)
        ana = 16'hA5C3;
        conv_check(8'h00, 4 + CONV, "R6 short conversion length");
        #2 chk(irq == 1, "R7 irq at completion", irq, 1);
        rd(2'd0, v); chk(v[6] == 1'b1, "R7 completion flag", v[6], 1);
        rd(2'd3, v); chk(v == 16'hA5C3, "R7 captured result", v, 16'hA5C3);
        #2 chk(irq == 0, "R8 read clears flag", irq, 0);

        for (int c = 0; c < 4; c++) begin
            int lt;
            case (c) 0: lt = 24; 1: lt = 16; 2: lt = 10; default: lt = 6; endcase
            conv_check({1'b0, 2'(c), 1'b1, 4'b0}, lt + CONV, "R4 long sample");
        end
        conv_check(8'h80, 4 + CONV + 2, "R5 high-speed extra cycles");
        conv_check(8'hF0, 6 + CONV + 2, "R5 high-speed with long sample");
        for (int d = 1; d < 4; d++)
            conv_check({4'b0, 2'(d), 2'b00}, (4 + CONV) << d, "R3 divider");
        for (int s = 1; s < 4; s++)
            conv_check({4'b0, 2'b01, 2'(s)}, (4 + CONV) * 2, "R2 clock source");

        // interrupt disabled
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h05);
        measure(0, n);
        #2 chk(irq == 0, "R7 irq masked", irq, 0);
        rd(2'd0, v); chk(v[6] == 1'b1, "R7 flag set while masked", v[6], 1);

        // abort and restart
        wr(2'd0, 8'h23);
        measure(0, n);
        wr(2'd0, 8'h24);
        #2 chk(irq == 0, "R8 control write clears flag", irq, 0);
        chk(busy == 1, "R8 new conversion running", busy, 1);
        repeat (6) @(negedge clk);
        wr(2'd0, 8'h25);
        measure(0, n);
        chk(n == 4 + CONV, "R8 restart full length", n, 4 + CONV);

        // channel 1F keeps the block off
        wr(2'd2, 8'h01);
        wr(2'd0, 8'h3F);
        pulse_hw();
        seen = 0;
        for (int i = 0; i < 40; i++) begin #2; if (busy) seen = 1; @(negedge clk); end
        chk(!seen, "R9 hw trigger ignored when off", seen, 0);
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h1F);
        seen = 0;
        for (int i = 0; i < 30; i++) begin #2; if (busy) seen = 1; @(negedge clk); end
        chk(!seen, "R9 software write ignored when off", seen, 0);
        rd(2'd0, v); chk(v[4:0] == 5'h1F, "R9 channel readback", v[4:0], 31);

        // hardware trigger
        wr(2'd2, 8'h01);
        wr(2'd0, 8'h22);
        seen = 0;
        for (int i = 0; i < 10; i++) begin #2; if (busy) seen = 1; @(negedge clk); end
        chk(!seen, "R10 write only arms", seen, 0);
        ana = 16'h1234;
        pulse_hw();
        measure(0, n);
        chk(n == 4 + CONV, "R10 hw started conversion length", n, 4 + CONV);
        rd(2'd3, v); chk(v == 16'h1234, "R10 hw result", v, 16'h1234);

        // continuous
        wr(2'd2, 8'h02);
        ana = 16'h0BEE;
        wr(2'd0, 8'h21);
        n = 0;
        for (int i = 0; i < 200; i++) begin #2; if (irq) break; n++; @(negedge clk); end
        chk(n == 4 + CONV, "R11 first period", n, 4 + CONV);
        chk(busy == 1, "R11 busy held across boundary", busy, 1);
        ana = 16'h0C0D;
        rd(2'd3, v); chk(v == 16'h0BEE, "R11 first result", v, 16'h0BEE);
        for (int i = 0; i < 200; i++) begin #2; if (irq) break; @(negedge clk); end
        chk(busy == 1, "R11 still running", busy, 1);
        rd(2'd3, v); chk(v == 16'h0C0D, "R11 second result", v, 16'h0C0D);
        wr(2'd2, 8'h00);
        measure(0, n);
        chk(n <= 4 + CONV, "R11 stops after mode cleared", n, 4 + CONV);
        #2 chk(busy == 0, "R11 idle after stop", busy, 0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL R6 watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule